// File: doc/BRIEF.md
# Serial Ethernet Address Parser

This block sits beside an Ethernet receiver that delivers a received frame as a serial NRZ bit stream with its own bit clock. It brings the serial clock, the serial data and an active-low network-ready gate into the system clock domain. It looks for the end of the alternating preamble, marked by two consecutive 1 bits. It then packs the 96 address bits that follow into six 16-bit segments. The first three segments are the destination address and the next three are the source address. Each segment goes to a downstream consumer, such as a CAM lookup engine, with a one-cycle strobe, a DA/SA tag and a segment index.

The block also watches the serial clock. If the clock stays low for more than a set number of system cycles, the block declares it lost. A frame cut short this way is flagged as a loss of carrier. If the network-ready gate closes after a frame has started, the parser drops back to idle and raises an abort pulse. The consumer uses that pulse to discard any compare result still in flight. After the sixth segment, the rest of the frame is ignored until the serial clock stops or the gate closes.

Top module: `eth_addr_parser`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `seg_valid`, `frame_active`, `clk_ok`, `carrier_lost` and `abort` are 0 and `seg_data` is 0.
- R2: A frame starts only when a run of at least MIN_PRE (default 8) alternating bits is followed by two consecutive 1 bits. Address capture begins with the next bit and `frame_active` rises. A shorter alternating run followed by 1,1 does not start a frame.
- R3: Within a segment, the k-th received bit (k = 0..15) appears at `seg_data[k]`. Octets therefore arrive least-significant bit first, and the first octet sits in the low byte.
- R4: A complete frame yields exactly six segments in this order: `seg_is_sa`=0 with `seg_idx` 0,1,2, then `seg_is_sa`=1 with `seg_idx` 0,1,2. `seg_idx` is never 3.
- R5: `seg_valid` is high for exactly one system cycle per segment.
- R6: While `net_rdy_n` is high, serial bits are ignored. No frame starts, no segment is produced and no abort is raised from idle.
- R7: `clk_ok` is set by a rising edge of the synchronised serial clock. It is cleared when that clock stays low for more than LOS_LIMIT (default 16) consecutive system cycles. Bits are parsed only while `clk_ok` is 1.
- R8: If the serial clock is lost during address capture, `carrier_lost` pulses for one cycle, `frame_active` falls and no further segment of that frame appears.
- R9: If `net_rdy_n` goes high after a frame has started (during capture, or after the sixth segment but before the clock stops), `abort` pulses for one cycle and the parser returns to idle. If the gate closes in the same cycle as a segment-completing bit, the abort wins and that segment is not emitted.
- R10: After the sixth segment, further bits are ignored even if they look like preamble plus delimiter. A clock loss at that point does not raise `carrier_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial bit clock from the receiver (asynchronous) |
| ser_dat | input | 1 | Serial NRZ data, stable around the serial clock rising edge |
| net_rdy_n | input | 1 | Network-ready gate, low allows parsing (asynchronous) |
| seg_valid | output | 1 | One-cycle strobe for a new address segment |
| seg_is_sa | output | 1 | 0 = destination address, 1 = source address |
| seg_idx | output | 2 | Segment index within the address, 0..2 |
| seg_data | output | 16 | Segment contents |
| frame_active | output | 1 | High while address bits are being captured |
| clk_ok | output | 1 | Serial clock judged valid |
| carrier_lost | output | 1 | One-cycle pulse: serial clock lost during capture |
| abort | output | 1 | One-cycle pulse: gate closed mid-frame, discard in-flight results |

## Verification
The interesting collision is between the gate closing and the rising serial edge that completes a segment. The bench raises `net_rdy_n` at the same instant as the serial clock edge carrying the 16th bit of the second destination segment. Both signals pass through synchronisers of equal depth, so they reach the parser in the same system cycle. The result is correct only if the scoreboard sees the first segment alone, one abort pulse is counted and no second segment appears. A second case closes the gate after the sixth segment, while the clock is still within its low-time limit. This checks that the abort, not a silent loss of carrier, ends the frame.

// File: rtl/eth_addr_pkg.sv
package eth_addr_pkg;

    localparam int WORD_W        = 16;
    localparam int SEGS_PER_ADDR = 3;
    localparam int ADDR_SEGS     = 2 * SEGS_PER_ADDR;
    localparam int ADDR_BITS     = ADDR_SEGS * WORD_W;
    localparam int POS_W         = $clog2(WORD_W);
    localparam int BIT_CNT_W     = $clog2(ADDR_BITS);
    localparam int ORD_W         = BIT_CNT_W - POS_W;

    typedef enum logic [1:0] {
        PS_HUNT    = 2'd0,
        PS_CAPTURE = 2'd1,
        PS_DRAIN   = 2'd2
    } parse_state_e;

    typedef struct packed {
        logic              is_sa;
        logic [1:0]        idx;
        logic [WORD_W-1:0] data;
    } seg_t;

    function automatic seg_t make_seg(input logic [ORD_W-1:0] ord,
                                      input logic [WORD_W-1:0] d);
        seg_t s;
        s.is_sa = (ord >= ORD_W'(SEGS_PER_ADDR));
        s.idx   = s.is_sa ? 2'(ord - ORD_W'(SEGS_PER_ADDR)) : 2'(ord);
        s.data  = d;
        return s;
    endfunction

endpackage

// File: rtl/eth_serial_sync.sv
module eth_serial_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic net_rdy_n,
    output logic sclk_s,
    output logic sdat_s,
    output logic gate_open,
    output logic sclk_rise
);
    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] dt_q;
    logic [STAGES-1:0] gt_q;
    logic              ck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q    <= '0;
            dt_q    <= '0;
            gt_q    <= '1;
            ck_prev <= 1'b0;
        end else begin
            ck_q    <= {ck_q[STAGES-2:0], ser_clk};
            dt_q    <= {dt_q[STAGES-2:0], ser_dat};
            gt_q    <= {gt_q[STAGES-2:0], net_rdy_n};
            ck_prev <= ck_q[STAGES-1];
        end
    end

    assign sclk_s    = ck_q[STAGES-1];
    assign sdat_s    = dt_q[STAGES-1];
    assign gate_open = ~gt_q[STAGES-1];
    assign sclk_rise = ck_q[STAGES-1] & ~ck_prev;

endmodule

// File: rtl/eth_clk_watchdog.sv
module eth_clk_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic sclk_rise,
    output logic clk_ok,
    output logic los_evt
);
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LIMIT + 1);

    logic [CNT_W-1:0] low_cnt;

    // the current low cycle is the (low_cnt+1)-th in a row
    assign los_evt = ~sclk_s && (low_cnt == CNT_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            clk_ok  <= 1'b0;
        end else begin
            if (sclk_s)
                low_cnt <= '0;
            else if (low_cnt != CNT_SAT)
                low_cnt <= low_cnt + 1'b1;

            if (los_evt)
                clk_ok <= 1'b0;
            else if (sclk_rise)
                clk_ok <= 1'b1;
        end
    end

endmodule

// File: rtl/eth_addr_framer.sv
module eth_addr_framer
    import eth_addr_pkg::*;
#(
    parameter int MIN_PRE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic gate_open,
    input  logic clk_ok,
    input  logic los_evt,
    output logic seg_valid,
    output seg_t seg,
    output logic abort,
    output logic carrier_lost,
    output logic active
);
    localparam int ALT_W = $clog2(MIN_PRE + 1);
    localparam logic [ALT_W-1:0]     ALT_MIN  = ALT_W'(MIN_PRE);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(ADDR_BITS - 1);
    localparam logic [POS_W-1:0]     LAST_POS = POS_W'(WORD_W - 1);

    parse_state_e         state;
    logic                 prev_bit;
    logic [ALT_W-1:0]     alt_cnt;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [WORD_W-1:0]    word;
    logic [POS_W-1:0]     pos;

    assign pos    = bit_cnt[POS_W-1:0];
    assign active = (state == PS_CAPTURE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= PS_HUNT;
            prev_bit     <= 1'b0;
            alt_cnt      <= '0;
            bit_cnt      <= '0;
            word         <= '0;
            seg_valid    <= 1'b0;
            seg          <= '0;
            abort        <= 1'b0;
            carrier_lost <= 1'b0;
        end else begin
            seg_valid    <= 1'b0;
            abort        <= 1'b0;
            carrier_lost <= 1'b0;
            unique case (state)
                PS_HUNT: begin
                    if (!gate_open) begin
                        prev_bit <= 1'b0;
                        alt_cnt  <= '0;
                    end else if (bit_stb && clk_ok) begin
                        if (bit_val != prev_bit) begin
                            if (alt_cnt != ALT_MIN)
                                alt_cnt <= alt_cnt + 1'b1;
                        end else begin
                            if (bit_val && (alt_cnt == ALT_MIN)) begin
                                state   <= PS_CAPTURE;
                                bit_cnt <= '0;
                                word    <= '0;
                            end
                            alt_cnt <= '0;
                        end
                        prev_bit <= bit_val;
                    end
                end
                PS_CAPTURE: begin
                    if (!gate_open) begin
                        abort    <= 1'b1;
                        state    <= PS_HUNT;
                        word     <= '0;
                        prev_bit <= 1'b0;
                        alt_cnt  <= '0;
                    end else if (los_evt) begin
                        carrier_lost <= 1'b1;
                        state        <= PS_HUNT;
                        word         <= '0;
                        prev_bit     <= 1'b0;
                        alt_cnt      <= '0;
                    end else if (bit_stb) begin
                        word[pos] <= bit_val;
                        bit_cnt   <= bit_cnt + 1'b1;
                        if (pos == LAST_POS) begin
                            seg_valid <= 1'b1;
                            seg       <= make_seg(bit_cnt[BIT_CNT_W-1:POS_W],
                                                  {bit_val, word[WORD_W-2:0]});
                        end
                        if (bit_cnt == LAST_BIT)
                            state <= PS_DRAIN;
                    end
                end
                PS_DRAIN: begin
                    if (!gate_open) begin
                        abort    <= 1'b1;
                        state    <= PS_HUNT;
                        prev_bit <= 1'b0;
                        alt_cnt  <= '0;
                    end else if (los_evt) begin
                        state    <= PS_HUNT;
                        prev_bit <= 1'b0;
                        alt_cnt  <= '0;
                    end
                end
                default: state <= PS_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/eth_addr_parser.sv
module eth_addr_parser
    import eth_addr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOS_LIMIT   = 16,
    parameter int MIN_PRE     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              net_rdy_n,
    output logic              seg_valid,
    output logic              seg_is_sa,
    output logic [1:0]        seg_idx,
    output logic [WORD_W-1:0] seg_data,
    output logic              frame_active,
    output logic              clk_ok,
    output logic              carrier_lost,
    output logic              abort
);
    logic sclk_s;
    logic sdat_s;
    logic gate_open;
    logic sclk_rise;
    logic los_evt;
    seg_t seg;

    eth_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .net_rdy_n (net_rdy_n),
        .sclk_s    (sclk_s),
        .sdat_s    (sdat_s),
        .gate_open (gate_open),
        .sclk_rise (sclk_rise)
    );

    eth_clk_watchdog #(.LIMIT(LOS_LIMIT)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (sclk_s),
        .sclk_rise (sclk_rise),
        .clk_ok    (clk_ok),
        .los_evt   (los_evt)
    );

    eth_addr_framer #(.MIN_PRE(MIN_PRE)) u_framer (
        .clk          (clk),
        .rst          (rst),
        .bit_stb      (sclk_rise),
        .bit_val      (sdat_s),
        .gate_open    (gate_open),
        .clk_ok       (clk_ok),
        .los_evt      (los_evt),
        .seg_valid    (seg_valid),
        .seg          (seg),
        .abort        (abort),
        .carrier_lost (carrier_lost),
        .active       (frame_active)
    );

    assign seg_is_sa = seg.is_sa;
    assign seg_idx   = seg.idx;
    assign seg_data  = seg.data;

endmodule

// File: rtl/eth_addr_parser_chk.sv
module eth_addr_parser_chk (
    input logic       clk,
    input logic       rst,
    input logic       net_rdy_n,
    input logic       seg_valid,
    input logic [1:0] seg_idx,
    input logic       frame_active,
    input logic       clk_ok,
    input logic       carrier_lost,
    input logic       abort
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!seg_valid && !frame_active && !clk_ok && !abort && !carrier_lost)); // R1

    AST_SEG_IDX_LEGAL: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_idx != 2'd3)); // R4

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        seg_valid |=> !seg_valid); // R5

    AST_GATE_BLOCKS_SEG: assert property (@(posedge clk) disable iff (rst)
        $past(net_rdy_n, 3) |-> !seg_valid); // R6

    AST_SEG_NEEDS_CLK_OK: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> clk_ok); // R7

    AST_LOST_CLEARS_OK: assert property (@(posedge clk) disable iff (rst)
        carrier_lost |-> (!clk_ok && !frame_active && !seg_valid)); // R8

    AST_ABORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        abort |-> (!seg_valid && !carrier_lost && !frame_active)); // R9

endmodule

bind eth_addr_parser eth_addr_parser_chk u_chk (.*);

// File: tb/test_eth_addr_parser.sv
`timescale 1ns/1ps
module test_eth_addr_parser;

    typedef struct packed {
        logic        sa;
        logic [1:0]  idx;
        logic [15:0] d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        net_rdy_n = 1'b0;
    logic        seg_valid;
    logic        seg_is_sa;
    logic [1:0]  seg_idx;
    logic [15:0] seg_data;
    logic        frame_active;
    logic        clk_ok;
    logic        carrier_lost;
    logic        abort;

    int n_checks = 0;
    int n_fail   = 0;
    int abort_cnt = 0;
    int lost_cnt  = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    eth_addr_parser i_eth_addr_parser (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .net_rdy_n(net_rdy_n), .seg_valid(seg_valid), .seg_is_sa(seg_is_sa),
        .seg_idx(seg_idx), .seg_data(seg_data), .frame_active(frame_active),
        .clk_ok(clk_ok), .carrier_lost(carrier_lost), .abort(abort)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop and pulse counters
    always @(negedge clk) begin
        if (!rst) begin
            if (abort) abort_cnt++;
            if (carrier_lost) lost_cnt++;
            if (seg_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4/R6", "unexpected segment", int'(seg_data), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({seg_is_sa, seg_idx, seg_data} == e, "R3/R4", "segment",
                        int'({seg_is_sa, seg_idx, seg_data}), int'(e));
                end
            end
        end
    end

    task automatic send_bit(input logic b);
        ser_dat = b;
        #20 ser_clk = 1'b1;
        #20 ser_clk = 1'b0;
    endtask

    task automatic send_pre(input int pairs);
        for (int i = 0; i < pairs; i++) begin
            send_bit(1'b1);
            send_bit(1'b0);
        end
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int k = 0; k < 16; k++) send_bit(w[k]);
    endtask

    task automatic push(input int ord, input logic [15:0] w);
        exp_t e;
        e.sa  = (ord >= 3);
        e.idx = 2'((ord >= 3) ? ord - 3 : ord);
        e.d   = w;
        q.push_back(e);
    endtask

    task automatic send_frame(input logic [95:0] a, input bit expect_out);
        send_pre(31);
        for (int s = 0; s < 6; s++) begin
            if (expect_out) push(s, a[16*s +: 16]);
            send_word(a[16*s +: 16]);
        end
    endtask

    task automatic gap();
        ser_clk = 1'b0;
        #200;
    endtask

    initial begin
        #600000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int ab0;
        int lo0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(seg_valid == 0, "R1", "seg_valid", seg_valid, 0);
        chk(frame_active == 0, "R1", "frame_active", frame_active, 0);
        chk(clk_ok == 0, "R1", "clk_ok", clk_ok, 0);
        chk(carrier_lost == 0 && abort == 0, "R1", "pulses", carrier_lost + abort, 0);
        chk(seg_data == 0, "R1", "seg_data", seg_data, 0);
        rst = 1'b0;
        #200;

        // R2 R3 R4 R7: plain frame, single-bit words locate bit 0 and bit 15
        send_pre(31);
        chk(frame_active == 1, "R2", "frame_active after delimiter", frame_active, 1);
        chk(clk_ok == 1, "R7", "clk_ok while clocking", clk_ok, 1);
        push(0, 16'h0001); send_word(16'h0001);
        push(1, 16'h8000); send_word(16'h8000);
        push(2, 16'h12F0); send_word(16'h12F0);
        push(3, 16'hA55A); send_word(16'hA55A);
        push(4, 16'hFFFF); send_word(16'hFFFF);
        push(5, 16'h0000); send_word(16'h0000);
        gap();
        chk(q.size() == 0, "R4", "segments outstanding", q.size(), 0);
        chk(clk_ok == 0, "R7", "clk_ok after long low", clk_ok, 0);
        chk(lost_cnt == 0, "R10", "carrier_lost after complete frame", lost_cnt, 0);

        // R10: preamble-like payload after SA is ignored
        send_frame(96'h0123_4567_89AB_CDEF_5555_AAAA, 1'b1);
        send_pre(10);
        send_word(16'hBEEF);
        send_word(16'h1234);
        gap();
        chk(q.size() == 0, "R10", "segments outstanding", q.size(), 0);
        chk(lost_cnt == 0, "R10", "carrier_lost", lost_cnt, 0);

        // R2: short alternating run then 1,1 does not start a frame
        send_pre(2);
        chk(frame_active == 0, "R2", "frame_active after short preamble", frame_active, 0);
        for (int i = 0; i < 96; i++) send_bit(1'b0);
        gap();

        // R6: gate closed for a whole frame
        ab0 = abort_cnt;
        net_rdy_n = 1'b1;
        #40;
        send_pre(31);
        chk(frame_active == 0, "R6", "frame_active with gate closed", frame_active, 0);
        for (int s = 0; s < 6; s++) send_word(16'h7E7E);
        gap();
        chk(abort_cnt == ab0, "R6", "abort from idle", abort_cnt, ab0);
        net_rdy_n = 1'b0;
        #40;

        // R9: gate closes on the same serial edge that completes DA segment 1
        ab0 = abort_cnt;
        send_pre(31);
        push(0, 16'hC3C3); send_word(16'hC3C3);
        for (int k = 0; k < 15; k++) send_bit(1'b1);
        ser_dat = 1'b1;
        #20;
        ser_clk = 1'b1;
        net_rdy_n = 1'b1;
        #20 ser_clk = 1'b0;
        gap();
        chk(abort_cnt == ab0 + 1, "R9", "abort count", abort_cnt, ab0 + 1);
        chk(q.size() == 0, "R9", "segments outstanding", q.size(), 0);
        chk(frame_active == 0, "R9", "frame_active after abort", frame_active, 0);
        net_rdy_n = 1'b0;
        #40;

        // R8: clock lost in the middle of capture, then recovery
        lo0 = lost_cnt;
        send_pre(31);
        push(0, 16'h0F0F); send_word(16'h0F0F);
        for (int k = 0; k < 5; k++) send_bit(1'b1);
        gap();
        chk(lost_cnt == lo0 + 1, "R8", "carrier_lost count", lost_cnt, lo0 + 1);
        chk(frame_active == 0, "R8", "frame_active after loss", frame_active, 0);
        chk(clk_ok == 0, "R7", "clk_ok after loss", clk_ok, 0);
        send_frame(96'hDEAD_BEEF_CAFE_0102_0304_0506, 1'b1);
        gap();
        chk(q.size() == 0, "R8", "segments after recovery", q.size(), 0);

        // R9: gate closes after the sixth segment, before the clock stops
        ab0 = abort_cnt;
        lo0 = lost_cnt;
        send_frame(96'h1111_2222_3333_4444_5555_6666, 1'b1);
        net_rdy_n = 1'b1;
        #200;
        chk(abort_cnt == ab0 + 1, "R9", "abort after addresses", abort_cnt, ab0 + 1);
        chk(lost_cnt == lo0, "R10", "carrier_lost after addresses", lost_cnt, lo0);
        chk(q.size() == 0, "R4", "segments outstanding", q.size(), 0);
        net_rdy_n = 1'b0;
        #40;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule